// File: doc/BRIEF.md
# Masked Lockstep Vector Array Controller

This block is a small array processor. A sequencer steps through its own instruction memory, one word per clock. It runs scalar work itself on a private register file: loading immediates, adding, subtracting, loading the element mask, branching and halting. When an instruction is marked as vector, the sequencer sends it in the same cycle to a row of identical processing elements. Each element reads two operands from its own private memory and writes one result back. An element takes part only while its bit in the mask register is set. An element whose bit is clear leaves its memory untouched.

Before a run, software loads programs through an instruction load port and fills the private memories through a data load port. A `start` pulse launches the program at address 0. The `done` output rises when a halt executes, and it stays high until the next start. A readback port gives combinational access to any word of any element.

Top module: `simd_array_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `pc` are 0, and the mask register holds all ones, so every element is enabled.
- R2: A `start` high at a clock edge while the controller is not busy begins sequencing at address 0. The controller executes one instruction per clock. A run that executes n instructions, the final halt included, shows `done` high just after the n-th edge following the start edge.
- R3: The instruction word is 24 bits wide. Bit 23 selects vector (1) or scalar (0). Bits 22:20 hold the opcode, bits 19:16 the destination, bits 15:12 source A, bits 11:8 source B and bits 7:0 an immediate. The vector opcodes are 0 add, 1 subtract (A-B), 2 multiply (low 16 bits), 3 and, 4 or, 5 xor, 6 move A, and 7 broadcast of scalar register B. Every enabled element computes with its own memory words at A and B and writes its destination in that same cycle.
- R4: An element whose mask bit is 0 keeps every word of its private memory unchanged while a vector instruction executes.
- R5: Scalar opcode 4 copies the low NUM_PE bits of scalar register A into the mask. Bit i of the mask enables element i. No other instruction changes the mask.
- R6: Scalar opcode 5 jumps to the immediate when scalar register A is zero and otherwise falls through to pc+1. Scalar opcode 6 always jumps to the immediate.
- R7: Scalar opcode 7 stops sequencing. On the next edge `done` goes high and `busy` goes low, and `done` then holds until a new `start`.
- R8: The load ports write only while the controller is not busy. A private memory load reaches only the element chosen by `pm_sel`. Loads presented during a run are ignored.
- R9: Scalar opcodes 0 no-op, 1 load zero-extended immediate, 2 add and 3 subtract act on the scalar registers, indexed by the low bits of the destination and source fields. No scalar instruction writes any private memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the program at address 0 |
| im_we | input | 1 | Instruction memory write strobe |
| im_addr | input | 5 | Instruction memory write address |
| im_data | input | 24 | Instruction word to store |
| pm_we | input | 1 | Private memory write strobe |
| pm_sel | input | 2 | Element receiving the private memory write |
| pm_addr | input | 4 | Private memory write address |
| pm_data | input | 16 | Private memory write data |
| rd_sel | input | 2 | Element for readback |
| rd_addr | input | 4 | Word address for readback |
| rd_data | output | 16 | Readback word (combinational) |
| busy | output | 1 | Program running |
| done | output | 1 | Halt reached |
| pc | output | 5 | Current instruction address |

## Verification
Every instruction takes one clock. Scalar results, mask loads and vector writebacks therefore land at the edge that executes them, and `done` appears at the edge that executes the halt. The bench drives on falling edges and counts falling edges from the start pulse until `done`. It compares that count with the number of instructions the program executes, so a stalled or skipped cycle shows up. It reads every memory result only after `done`, through the combinational readback port, half a cycle after the last write could have happened.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W  = 16;
    localparam int PM_AW   = 4;
    localparam int PM_DEPTH = 1 << PM_AW;
    localparam int IMM_W   = 8;
    localparam int OP_W    = 3;
    localparam int INSTR_W = 1 + OP_W + 3 * PM_AW + IMM_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PM_AW-1:0]  pmaddr_t;

    typedef struct packed {
        logic             is_vec;
        logic [OP_W-1:0]  op;
        pmaddr_t          dst;
        pmaddr_t          src_a;
        pmaddr_t          src_b;
        logic [IMM_W-1:0] imm;
    } instr_t;

    typedef enum logic [OP_W-1:0] {
        V_ADD   = 3'd0,
        V_SUB   = 3'd1,
        V_MUL   = 3'd2,
        V_AND   = 3'd3,
        V_OR    = 3'd4,
        V_XOR   = 3'd5,
        V_MOV   = 3'd6,
        V_BCAST = 3'd7
    } vop_e;

    typedef enum logic [OP_W-1:0] {
        S_NOP  = 3'd0,
        S_LDI  = 3'd1,
        S_ADD  = 3'd2,
        S_SUB  = 3'd3,
        S_MASK = 3'd4,
        S_BEQZ = 3'd5,
        S_JMP  = 3'd6,
        S_HALT = 3'd7
    } sop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // Lane arithmetic shared by every processing element.
    function automatic word_t vec_alu(vop_e op, word_t a, word_t b, word_t scal);
        logic [2*DATA_W-1:0] prod;
        word_t               res;
        prod = a * b;
        case (op)
            V_ADD:   res = a + b;
            V_SUB:   res = a - b;
            V_MUL:   res = prod[DATA_W-1:0];
            V_AND:   res = a & b;
            V_OR:    res = a | b;
            V_XOR:   res = a ^ b;
            V_MOV:   res = a;
            default: res = scal;
        endcase
        return res;
    endfunction

    // True for scalar opcodes that redirect or stop the program counter.
    function automatic logic is_flow_op(logic [OP_W-1:0] op);
        return (op == S_BEQZ) || (op == S_JMP) || (op == S_HALT);
    endfunction

endpackage

// File: rtl/simd_imem.sv
module simd_imem
    import simd_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  instr_t        wdata,
    input  logic [AW-1:0] raddr,
    output instr_t        rdata
);

    instr_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/simd_seq.sv
module simd_seq
    import simd_pkg::*;
#(
    parameter int NUM_PE   = 4,
    parameter int IM_AW    = 5,
    parameter int NUM_SREG = 4,
    localparam int SRW = $clog2(NUM_SREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  instr_t            instr,
    output logic [IM_AW-1:0]  pc,
    output logic              busy,
    output logic              done,
    output logic              vec_fire,
    output logic [NUM_PE-1:0] mask,
    output word_t             scal
);

    seq_state_e        state_q;
    logic [IM_AW-1:0]  pc_q;
    logic [NUM_PE-1:0] mask_q;
    word_t             sreg_q [NUM_SREG];

    logic [SRW-1:0]   ra_idx, rb_idx, rd_idx;
    word_t            ra_val, rb_val;
    logic [IM_AW-1:0] target;
    logic [IM_AW-1:0] pc_inc;
    logic             running;

    assign ra_idx  = instr.src_a[SRW-1:0];
    assign rb_idx  = instr.src_b[SRW-1:0];
    assign rd_idx  = instr.dst[SRW-1:0];
    assign ra_val  = sreg_q[ra_idx];
    assign rb_val  = sreg_q[rb_idx];
    assign target  = instr.imm[IM_AW-1:0];
    assign pc_inc  = pc_q + 1'b1;
    assign running = (state_q == ST_RUN);

    logic unused_fields;
    assign unused_fields = ^{instr.imm, instr.src_a, instr.src_b, instr.dst};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            mask_q  <= '1;
            for (int i = 0; i < NUM_SREG; i++) begin
                sreg_q[i] <= '0;
            end
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (instr.is_vec) begin
                        pc_q <= pc_inc;
                    end else begin
                        case (sop_e'(instr.op))
                            S_LDI: begin
                                sreg_q[rd_idx] <= word_t'(instr.imm);
                                pc_q <= pc_inc;
                            end
                            S_ADD: begin
                                sreg_q[rd_idx] <= ra_val + rb_val;
                                pc_q <= pc_inc;
                            end
                            S_SUB: begin
                                sreg_q[rd_idx] <= ra_val - rb_val;
                                pc_q <= pc_inc;
                            end
                            S_MASK: begin
                                mask_q <= ra_val[NUM_PE-1:0];
                                pc_q   <= pc_inc;
                            end
                            S_BEQZ: begin
                                pc_q <= (ra_val == '0) ? target : pc_inc;
                            end
                            S_JMP: begin
                                pc_q <= target;
                            end
                            S_HALT: begin
                                state_q <= ST_DONE;
                            end
                            default: begin
                                pc_q <= pc_inc;
                            end
                        endcase
                    end
                end
                default: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        pc_q    <= '0;
                    end
                end
            endcase
        end
    end

    assign pc       = pc_q;
    assign busy     = running;
    assign done     = (state_q == ST_DONE);
    assign vec_fire = running && instr.is_vec;
    assign mask     = mask_q;
    assign scal     = rb_val;

endmodule

// File: rtl/simd_pe.sv
module simd_pe
    import simd_pkg::*;
(
    input  logic    clk,
    input  logic    vec_en,
    input  instr_t  instr,
    input  word_t   scal,
    input  logic    host_we,
    input  pmaddr_t host_addr,
    input  word_t   host_data,
    input  pmaddr_t rd_addr,
    output word_t   rd_data
);

    word_t mem [PM_DEPTH];
    word_t opa, opb, res;

    assign opa = mem[instr.src_a];
    assign opb = mem[instr.src_b];
    assign res = vec_alu(vop_e'(instr.op), opa, opb, scal);

    logic unused_fields;
    assign unused_fields = ^{instr.is_vec, instr.imm};

    always_ff @(posedge clk) begin
        if (vec_en) begin
            mem[instr.dst] <= res;
        end else if (host_we) begin
            mem[host_addr] <= host_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/simd_array_ctrl.sv
module simd_array_ctrl
    import simd_pkg::*;
#(
    parameter int NUM_PE   = 4,
    parameter int IM_DEPTH = 32,
    parameter int NUM_SREG = 4,
    localparam int IM_AW = $clog2(IM_DEPTH),
    localparam int PEW   = $clog2(NUM_PE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               im_we,
    input  logic [IM_AW-1:0]   im_addr,
    input  logic [INSTR_W-1:0] im_data,
    input  logic               pm_we,
    input  logic [PEW-1:0]     pm_sel,
    input  logic [PM_AW-1:0]   pm_addr,
    input  logic [DATA_W-1:0]  pm_data,
    input  logic [PEW-1:0]     rd_sel,
    input  logic [PM_AW-1:0]   rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               busy,
    output logic               done,
    output logic [IM_AW-1:0]   pc
);

    instr_t            instr;
    logic              vec_fire;
    logic [NUM_PE-1:0] mask_q;
    word_t             scal;
    logic              load_ok;
    word_t             pe_rd [NUM_PE];

    assign load_ok = !busy;

    simd_imem #(.DEPTH(IM_DEPTH)) u_imem (
        .clk   (clk),
        .we    (im_we && load_ok),
        .waddr (im_addr),
        .wdata (instr_t'(im_data)),
        .raddr (pc),
        .rdata (instr)
    );

    simd_seq #(
        .NUM_PE   (NUM_PE),
        .IM_AW    (IM_AW),
        .NUM_SREG (NUM_SREG)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .instr    (instr),
        .pc       (pc),
        .busy     (busy),
        .done     (done),
        .vec_fire (vec_fire),
        .mask     (mask_q),
        .scal     (scal)
    );

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        simd_pe u_pe (
            .clk       (clk),
            .vec_en    (vec_fire && mask_q[g]),
            .instr     (instr),
            .scal      (scal),
            .host_we   (pm_we && load_ok && (pm_sel == PEW'(g))),
            .host_addr (pm_addr),
            .host_data (pm_data),
            .rd_addr   (rd_addr),
            .rd_data   (pe_rd[g])
        );
    end

    assign rd_data = pe_rd[rd_sel];

endmodule

// File: rtl/simd_array_ctrl_chk.sv
module simd_array_ctrl_chk
    import simd_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int IM_AW  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [IM_AW-1:0]  pc,
    input logic [NUM_PE-1:0] mask,
    input instr_t            instr
);

    logic scal_now;
    assign scal_now = busy && !instr.is_vec;

    logic unused_fields;
    assign unused_fields = ^{instr.dst, instr.src_a, instr.src_b, instr.imm};

    AST_RUN_XOR_DONE: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R7

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && pc == '0)); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && (instr.is_vec || !is_flow_op(instr.op))) |=> (pc == IM_AW'($past(pc) + 1'b1))); // R2

    AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (rst)
        (scal_now && instr.op == S_JMP) |=> (pc == $past(instr.imm[IM_AW-1:0]))); // R6

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (scal_now && instr.op == S_HALT) |=> (done && !busy)); // R7

    AST_DONE_STICKS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R7

    AST_MASK_ONLY_BY_OP: assert property (@(posedge clk) disable iff (rst)
        !(scal_now && instr.op == S_MASK) |=> $stable(mask)); // R5

endmodule

bind simd_array_ctrl simd_array_ctrl_chk #(
    .NUM_PE (NUM_PE),
    .IM_AW  (IM_AW)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .pc    (pc),
    .mask  (mask_q),
    .instr (instr)
);

// File: tb/simd_array_ctrl_tb.sv
module simd_array_ctrl_tb;

    localparam int NPE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        im_we = 1'b0;
    logic [4:0]  im_addr = '0;
    logic [23:0] im_data = '0;
    logic        pm_we = 1'b0;
    logic [1:0]  pm_sel = '0;
    logic [3:0]  pm_addr = '0;
    logic [15:0] pm_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy, done;
    logic [4:0]  pc;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    simd_array_ctrl u_dut (
        .clk(clk), .rst(rst), .start(start),
        .im_we(im_we), .im_addr(im_addr), .im_data(im_data),
        .pm_we(pm_we), .pm_sel(pm_sel), .pm_addr(pm_addr), .pm_data(pm_data),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .pc(pc)
    );

    function automatic logic [23:0] enc(input logic v, input logic [2:0] op,
                                        input logic [3:0] d, input logic [3:0] a,
                                        input logic [3:0] b, input logic [7:0] imm);
        return {v, op, d, a, b, imm};
    endfunction

    function automatic logic [15:0] lane_expect(input int op, input logic [15:0] a,
                                                input logic [15:0] b, input logic [15:0] s);
        logic [31:0] p;
        p = a * b;
        case (op)
            0: return a + b;
            1: return a - b;
            2: return p[15:0];
            3: return a & b;
            4: return a | b;
            5: return a ^ b;
            6: return a;
            default: return s;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_im(input int addr, input logic [23:0] w);
        @(negedge clk);
        im_we = 1'b1; im_addr = 5'(addr); im_data = w;
        @(negedge clk);
        im_we = 1'b0;
    endtask

    task automatic put_pm(input int pe, input int addr, input logic [15:0] d);
        @(negedge clk);
        pm_we = 1'b1; pm_sel = 2'(pe); pm_addr = 4'(addr); pm_data = d;
        @(negedge clk);
        pm_we = 1'b0;
    endtask

    task automatic get_pm(input int pe, input int addr, output logic [15:0] d);
        rd_sel = 2'(pe); rd_addr = 4'(addr);
        #1;
        d = rd_data;
    endtask

    // Pulses start and returns the number of edges until done is seen.
    task automatic run(output int n);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 pc", 32'(pc), 0);

        // R1: mask is all ones after reset, so a bare vector add reaches every element.
        for (int p = 0; p < NPE; p++) begin
            put_pm(p, 0, 16'(100 + p));
            put_pm(p, 1, 16'(7 * p + 1));
            put_pm(p, 2, 16'hFFFF);
        end
        put_im(0, enc(1, 0, 2, 0, 1, 0));
        put_im(1, enc(0, 7, 0, 0, 0, 0));
        run(n);
        check("R2 length of two-word run", 32'(n), 2);
        for (int p = 0; p < NPE; p++) begin
            get_pm(p, 2, v);
            check("R1 reset mask enables all", 32'(v), 32'(16'(100 + p + 7 * p + 1)));
        end

        // R3/R4/R5: every vector opcode under every mask value.
        for (int op = 0; op < 8; op++) begin
            for (int m = 0; m < 16; m++) begin
                logic [7:0] k;
                k = 8'(8'hA5 ^ (op * 17 + m));
                for (int p = 0; p < NPE; p++) begin
                    put_pm(p, 0, 16'((p * 16'h3141 + op * 16'h0519 + m * 16'h0077) ^ 16'h5A5A));
                    put_pm(p, 1, 16'((p * 16'h1F3 + op * 16'h2B + m * 16'h101) ^ 16'h0C3F));
                    put_pm(p, 2, 16'(16'hDEAD ^ p));
                end
                put_im(0, enc(0, 1, 0, 0, 0, 8'(m)));
                put_im(1, enc(0, 1, 1, 0, 0, k));
                put_im(2, enc(0, 4, 0, 0, 0, 0));
                put_im(3, enc(1, 3'(op), 2, 0, 1, 0));
                put_im(4, enc(0, 7, 0, 0, 0, 0));
                run(n);
                check("R2 run length", 32'(n), 5);
                for (int p = 0; p < NPE; p++) begin
                    logic [15:0] a, b, e;
                    a = 16'((p * 16'h3141 + op * 16'h0519 + m * 16'h0077) ^ 16'h5A5A);
                    b = 16'((p * 16'h1F3 + op * 16'h2B + m * 16'h101) ^ 16'h0C3F);
                    get_pm(p, 2, v);
                    if (m[p]) begin
                        e = lane_expect(op, a, b, {8'h00, k});
                        check("R3 R5 enabled lane result", 32'(v), 32'(e));
                    end else begin
                        check("R4 R5 disabled lane unchanged", 32'(v), 32'(16'(16'hDEAD ^ p)));
                    end
                    get_pm(p, 0, v);
                    check("R4 source word intact", 32'(v), 32'(a));
                end
            end
        end

        // R9: scalar arithmetic, exposed through broadcasts; scalar ops leave memory alone.
        for (int xi = 0; xi < 5; xi++) begin
            for (int yi = 0; yi < 5; yi++) begin
                logic [7:0] x, y;
                x = (xi == 0) ? 8'h00 : (xi == 1) ? 8'h01 : (xi == 2) ? 8'h7F : (xi == 3) ? 8'h80 : 8'hFF;
                y = (yi == 0) ? 8'h00 : (yi == 1) ? 8'h01 : (yi == 2) ? 8'h7F : (yi == 3) ? 8'h80 : 8'hFF;
                for (int p = 0; p < NPE; p++) put_pm(p, 6, 16'(16'hBEE0 + p));
                put_im(0, enc(0, 1, 2, 0, 0, 8'h0F));
                put_im(1, enc(0, 4, 0, 2, 0, 0));
                put_im(2, enc(0, 1, 0, 0, 0, x));
                put_im(3, enc(0, 1, 1, 0, 0, y));
                put_im(4, enc(0, 2, 2, 0, 1, 0));
                put_im(5, enc(0, 3, 3, 0, 1, 0));
                put_im(6, enc(1, 7, 4, 0, 2, 0));
                put_im(7, enc(1, 7, 5, 0, 3, 0));
                put_im(8, enc(0, 7, 0, 0, 0, 0));
                run(n);
                check("R2 nine-word run", 32'(n), 9);
                for (int p = 0; p < NPE; p++) begin
                    get_pm(p, 4, v);
                    check("R9 scalar add", 32'(v), 32'(16'({8'h00, x} + {8'h00, y})));
                    get_pm(p, 5, v);
                    check("R9 scalar sub", 32'(v), 32'(16'({8'h00, x} - {8'h00, y})));
                    get_pm(p, 6, v);
                    check("R9 untouched word", 32'(v), 32'(16'(16'hBEE0 + p)));
                end
            end
        end

        // R6/R8: counted loop, with loads attempted mid-run.
        for (int p = 0; p < NPE; p++) begin
            put_pm(p, 0, 16'(10 + p));
            put_pm(p, 1, 16'(3 + 2 * p));
            put_pm(p, 15, 16'h1234);
        end
        put_im(0, enc(0, 1, 2, 0, 0, 8'd3));
        put_im(1, enc(0, 1, 3, 0, 0, 8'd1));
        put_im(2, enc(1, 0, 0, 0, 1, 0));
        put_im(3, enc(0, 3, 2, 2, 3, 0));
        put_im(4, enc(0, 5, 0, 2, 0, 8'd6));
        put_im(5, enc(0, 6, 0, 0, 0, 8'd2));
        put_im(6, enc(0, 7, 0, 0, 0, 0));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pm_we = 1'b1; pm_sel = 2'd0; pm_addr = 4'd15; pm_data = 16'hBAD0;
        im_we = 1'b1; im_addr = 5'd6; im_data = enc(0, 0, 0, 0, 0, 0);
        n = 1;
        @(negedge clk);
        pm_we = 1'b0; im_we = 1'b0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R6 loop length with branch taken once", 32'(n), 14);
        check("R7 busy low at done", 32'(busy), 0);
        for (int p = 0; p < NPE; p++) begin
            get_pm(p, 0, v);
            check("R6 loop accumulation", 32'(v), 32'(16'(10 + p + 3 * (3 + 2 * p))));
            get_pm(p, 15, v);
            check("R8 load during run ignored", 32'(v), 32'(16'h1234));
        end
        repeat (4) @(negedge clk);
        check("R7 done holds", 32'(done), 1);
        check("R7 busy stays low", 32'(busy), 0);

        // R8: an idle load writes only the selected element.
        for (int p = 0; p < NPE; p++) put_pm(p, 9, 16'h0);
        put_pm(2, 9, 16'h7E57);
        for (int p = 0; p < NPE; p++) begin
            get_pm(p, 9, v);
            check("R8 selected element only", 32'(v), (p == 2) ? 32'h7E57 : 32'h0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule